// File: doc/BRIEF.md
# Programmable Homogeneous NFA Engine

This block runs a non-deterministic automaton over a stream of 8-bit symbols, taking one symbol per clock. It is built from a small array of state elements. Each element owns a 256-entry symbol-class mask and two attributes: a start flag and a report flag. Each element also owns a successor row that names the elements it wakes up. On every accepted symbol, all enabled elements test their mask bit for that symbol at the same time. An element is enabled when it was activated by the previous symbol or when it is a start element. Every element that hits activates its successors for the next symbol only. Nothing propagates within the same cycle.

All state is loaded through one configuration write port, and only while the stream is paused. A relabel is just a mask write. It changes which symbols an element accepts and leaves the wiring, the attributes and the current activation untouched. An automaton layout can therefore be reused for a new pattern of the same shape without rewriting the connection matrix.

For each accepted symbol the block registers a report vector: one bit per reporting element that hit. It also registers a combined any-report flag and the position of that symbol in the stream. All of these are valid in the cycle after the symbol is taken.

Top module: `nfa_engine`

## Requirements
- R1: An element hits on a symbol when it is enabled and the bit of its mask indexed by the symbol value is set. Mask word w (cfg_sel = 0, cfg_word = w) holds the symbols 32w to 32w+31, and data bit b of that word is symbol 32w+b.
- R2: A successor row write (cfg_sel = 1) loads data bits [NUM_STE-1:0] as the row of element cfg_elem: bit j set means a hit on element cfg_elem activates element j. An activated element is enabled for the next accepted symbol only.
- R3: There is no same-cycle propagation. An element that is neither a start element nor activated by the previous accepted symbol never hits, even when its mask matches.
- R4: A start element is enabled on every accepted symbol, so a match may begin at any stream position. An attribute write (cfg_sel = 2) sets the start flag from data bit 0 and the report flag from data bit 1.
- R5: In the cycle after an accepted symbol, rpt_vec bit i is 1 exactly when element i has its report flag set and hit on that symbol. rpt_any is the OR of rpt_vec.
- R6: rpt_valid is high exactly in the cycle after each accepted symbol (in_valid high). rpt_idx then gives that symbol's position, counted from 0 at the first symbol after reset.
- R7: A cycle with in_valid low changes neither the activation nor the position count, and rpt_valid and rpt_vec are 0 in the cycle that follows it.
- R8: A configuration write issued while in_valid is high has no effect.
- R9: A mask write leaves successor rows, attributes and the current activation unchanged. A match in progress therefore continues under the new masks.
- R10: A synchronous reset clears the activation, the position count and all report outputs, and keeps masks, rows and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of run state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mask word, 1 successor row, 2 attributes, 3 none |
| cfg_elem | input | $clog2(NUM_STE) | Element written |
| cfg_word | input | $clog2(256/DATA_W) | Mask word index |
| cfg_wdata | input | DATA_W | Write data |
| in_valid | input | 1 | Symbol present this cycle |
| in_char | input | SYM_W | Input symbol |
| rpt_valid | output | 1 | Report outputs belong to an accepted symbol |
| rpt_idx | output | IDX_W | Stream position of that symbol |
| rpt_vec | output | NUM_STE | Reporting elements that hit |
| rpt_any | output | 1 | Any bit of rpt_vec set |

## Verification
The bench uses the defaults: eight elements, 8-bit symbols, a 16-bit position count and 32-bit configuration words. With these values each mask spans eight words, so a single-word rewrite of the symbol 'c' (word 3, bit 3) tests the word and bit mapping directly. Eight elements leave room for four separate groups at once: a three-element chain, a two-element pair that exposes the missing same-cycle step, an orphan reporter, and two overlapping start reporters. As a result, parallel evaluation, restarts, relabel during a live match and reset retention can all be observed in one stream.

// File: rtl/nfa_engine.sv
module nfa_engine #(
  parameter int NUM_STE = 8,
  parameter int SYM_W   = 8,
  parameter int IDX_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [$clog2(NUM_STE)-1:0] cfg_elem,
  input  logic [$clog2((1<<SYM_W)/DATA_W)-1:0] cfg_word,
  input  logic [DATA_W-1:0]          cfg_wdata,
  input  logic                       in_valid,
  input  logic [SYM_W-1:0]           in_char,
  output logic                       rpt_valid,
  output logic [IDX_W-1:0]           rpt_idx,
  output logic [NUM_STE-1:0]         rpt_vec,
  output logic                       rpt_any
);
  localparam int NSYM   = 1 << SYM_W;
  localparam int NWORDS = NSYM / DATA_W;
  localparam int WSEL_W = $clog2(NWORDS);
  localparam int EL_W   = $clog2(NUM_STE);
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_SUCC = 2'd1;
  localparam logic [1:0] SEL_ATTR = 2'd2;

  logic [NSYM-1:0]    mask_q [NUM_STE];
  logic [NUM_STE-1:0] succ_q [NUM_STE];
  logic [1:0]         attr_q [NUM_STE];

  logic [NUM_STE-1:0] start_v, rep_v, active_q, enabled, hit, next_act;
  logic [NUM_STE*NUM_STE-1:0] conn_flat;
  logic [2*NUM_STE-1:0]       attr_flat;
  logic [IDX_W-1:0]           idx_q;
  logic cfg_ok;

  assign cfg_ok = cfg_we & ~in_valid;

  for (genvar g = 0; g < NUM_STE; g++) begin : g_ste
    logic sel_me;
    assign sel_me = cfg_ok && (cfg_elem == EL_W'(g));

    always_ff @(posedge clk) begin
      if (sel_me && cfg_sel == SEL_MASK)
        for (int w = 0; w < NWORDS; w++)
          if (cfg_word == WSEL_W'(w))
            mask_q[g][w*DATA_W +: DATA_W] <= cfg_wdata;
    end

    always_ff @(posedge clk) begin
      if (sel_me && cfg_sel == SEL_SUCC) succ_q[g] <= cfg_wdata[NUM_STE-1:0];
      if (sel_me && cfg_sel == SEL_ATTR) attr_q[g] <= cfg_wdata[1:0];
    end

    assign start_v[g] = attr_q[g][0];
    assign rep_v[g]   = attr_q[g][1];
    assign hit[g]     = enabled[g] & mask_q[g][in_char];
    assign conn_flat[g*NUM_STE +: NUM_STE] = succ_q[g];
    assign attr_flat[2*g +: 2] = attr_q[g];
  end

  assign enabled = active_q | start_v;

  always_comb begin
    next_act = '0;
    for (int j = 0; j < NUM_STE; j++)
      for (int i = 0; i < NUM_STE; i++)
        next_act[j] = next_act[j] | (hit[i] & succ_q[i][j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= '0;
      idx_q     <= '0;
      rpt_valid <= 1'b0;
      rpt_idx   <= '0;
      rpt_vec   <= '0;
    end else if (in_valid) begin
      active_q  <= next_act;
      idx_q     <= idx_q + 1'b1;
      rpt_valid <= 1'b1;
      rpt_idx   <= idx_q;
      rpt_vec   <= hit & rep_v;
    end else begin
      rpt_valid <= 1'b0;
      rpt_vec   <= '0;
    end
  end

  assign rpt_any = |rpt_vec;

  AST_RPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (|rpt_vec) |-> rpt_valid); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && $past(rpt_valid)) |-> rpt_idx == $past(rpt_idx) + 1'b1); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(active_q)); // R7
  AST_BUSY_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && in_valid) |=> ($stable(conn_flat) && $stable(attr_flat))); // R8
  AST_RELABEL_KEEPS_WIRING: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !in_valid && cfg_sel == SEL_MASK) |=>
      ($stable(conn_flat) && $stable(attr_flat) && $stable(active_q))); // R9
  AST_NO_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> ((rpt_vec & ~$past(active_q | start_v)) == '0)); // R3
endmodule

// File: tb/nfa_engine_tb.sv
module nfa_engine_tb_top;
  localparam int N = 8;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we, in_valid;
  logic [1:0] cfg_sel;
  logic [2:0] cfg_elem, cfg_word;
  logic [31:0] cfg_wdata;
  logic [7:0] in_char;
  logic rpt_valid, rpt_any;
  logic [15:0] rpt_idx;
  logic [N-1:0] rpt_vec;

  int checks = 0, errors = 0, nidx = 0;

  nfa_engine dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_elem(cfg_elem),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_char(in_char),
    .rpt_valid(rpt_valid), .rpt_idx(rpt_idx), .rpt_vec(rpt_vec), .rpt_any(rpt_any));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int el, input int wd, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_sel = sel;
    cfg_elem = 3'(el); cfg_word = 3'(wd); cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input int el, input string chars);
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < chars.len(); i++) m[chars[i]] = 1'b1;
    for (int w = 0; w < 8; w++) cfg(2'd0, el, w, m[w*32 +: 32]);
  endtask

  task automatic send(input byte c);
    @(negedge clk);
    in_valid = 1'b1; in_char = c;
    @(posedge clk); #2;
    nidx++;
  endtask

  task automatic send_chk(input string tag, input byte c, input logic [N-1:0] vec);
    int pos;
    pos = nidx;
    send(c);
    chk({tag, " vec"}, 32'(rpt_vec), 32'(vec));
    chk({tag, " any"}, 32'(rpt_any), 32'(|vec));
    chk({tag, " valid"}, 32'(rpt_valid), 32'd1);
    chk({tag, " idx"}, 32'(rpt_idx), 32'(pos));
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #2;
    chk({tag, " valid"}, 32'(rpt_valid), 32'd0);
    chk({tag, " vec"}, 32'(rpt_vec), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    nidx = 0;
  endtask

  task automatic t_reset_state();
    #1;
    chk("R10 reset valid", 32'(rpt_valid), 32'd0);
    chk("R10 reset vec", 32'(rpt_vec), 32'd0);
    chk("R10 reset any", 32'(rpt_any), 32'd0);
  endtask

  task automatic t_program();
    for (int e = 0; e < N; e++) begin
      cfg(2'd1, e, 0, 32'd0);
      cfg(2'd2, e, 0, 32'd0);
    end
    for (int e = 0; e < N; e++) set_mask(e, "");
    set_mask(0, "a"); cfg(2'd2, 0, 0, 32'h1); cfg(2'd1, 0, 0, 32'h02);
    set_mask(1, "b"); cfg(2'd1, 1, 0, 32'h04);
    set_mask(2, "c"); cfg(2'd2, 2, 0, 32'h2);
    set_mask(3, "q"); cfg(2'd2, 3, 0, 32'h2);
    set_mask(4, "k"); cfg(2'd2, 4, 0, 32'h1); cfg(2'd1, 4, 0, 32'h20);
    set_mask(5, "k"); cfg(2'd2, 5, 0, 32'h2);
    set_mask(6, "z"); cfg(2'd2, 6, 0, 32'h3);
    set_mask(7, "zy"); cfg(2'd2, 7, 0, 32'h3);
  endtask

  task automatic t_chain();
    send_chk("R1 x", "x", 8'h00);
    send_chk("R2 a", "a", 8'h00);
    send_chk("R2 b", "b", 8'h00);
    send_chk("R5 c", "c", 8'h04);
    send_chk("R4 a", "a", 8'h00);
    send_chk("R4 a2", "a", 8'h00);
    send_chk("R4 b", "b", 8'h00);
    send_chk("R4 c", "c", 8'h04);
    send_chk("R2 a skip", "a", 8'h00);
    send_chk("R2 c skip", "c", 8'h00);
  endtask

  task automatic t_no_epsilon();
    send_chk("R3 q orphan", "q", 8'h00);
    send_chk("R3 k first", "k", 8'h00);
    send_chk("R3 k second", "k", 8'h20);
  endtask

  task automatic t_multi();
    send_chk("R5 z both", "z", 8'hC0);
    send_chk("R5 y one", "y", 8'h80);
  endtask

  task automatic t_gap();
    send_chk("R7 a", "a", 8'h00);
    send_chk("R7 b", "b", 8'h00);
    for (int i = 0; i < 3; i++) idle_chk("R7 idle");
    send_chk("R7 c after gap", "c", 8'h04);
  endtask

  task automatic t_busy_cfg();
    @(negedge clk);
    in_valid = 1'b1; in_char = "x";
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_elem = 3'd2; cfg_word = 3'd3; cfg_wdata = 32'h0;
    @(posedge clk); #2;
    nidx++;
    @(negedge clk);
    in_char = "x"; cfg_sel = 2'd2; cfg_wdata = 32'h0;
    @(posedge clk); #2;
    nidx++;
    cfg_we = 1'b0;
    send_chk("R8 a", "a", 8'h00);
    send_chk("R8 b", "b", 8'h00);
    send_chk("R8 c still", "c", 8'h04);
  endtask

  task automatic t_relabel();
    set_mask(0, "d"); set_mask(1, "o"); set_mask(2, "g");
    send_chk("R9 d", "d", 8'h00);
    send_chk("R9 o", "o", 8'h00);
    send_chk("R9 g", "g", 8'h04);
    send_chk("R9 old a", "a", 8'h00);
    send_chk("R9 old b", "b", 8'h00);
    send_chk("R9 old c", "c", 8'h00);
    send_chk("R9 d live", "d", 8'h00);
    send_chk("R9 o live", "o", 8'h00);
    set_mask(2, "t");
    send_chk("R9 t after relabel", "t", 8'h04);
  endtask

  task automatic t_reset_keep();
    send_chk("R10 d", "d", 8'h00);
    send_chk("R10 o", "o", 8'h00);
    do_reset();
    #1;
    chk("R10 valid cleared", 32'(rpt_valid), 32'd0);
    chk("R10 vec cleared", 32'(rpt_vec), 32'd0);
    send_chk("R10 t no activation", "t", 8'h00);
    send_chk("R10 d", "d", 8'h00);
    send_chk("R10 o", "o", 8'h00);
    send_chk("R10 t config kept", "t", 8'h04);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; in_valid = 1'b0;
    cfg_sel = '0; cfg_elem = '0; cfg_word = '0; cfg_wdata = '0; in_char = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_program();
    t_chain();
    t_no_epsilon();
    t_multi();
    t_gap();
    t_busy_cfg();
    t_relabel();
    t_reset_keep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule